// File: doc/BRIEF.md
# Retention-Window Line Scrubber

This block runs in the background beside a cache whose slow data ways keep their contents only for a bounded retention time and have no refresh. It steps through every line of the slow ways, one line per scrub interval, reading only the separate tag/control array. A line that is not valid is passed over. A valid clean line is invalidated. A valid dirty line is first written back to the next cache level, and then invalidated. Every slow line is therefore emptied before its charge can decay.

A single free-running countdown sets the pace. Its period is the retention time divided by the number of slow lines. A dirty line's writeback needs the data bank of its way. While that bank is busy serving the main controller, the scrubber waits and keeps its pointer in place. The countdown keeps running during the wait. Each interval that expires during the wait is recorded as an owed step and is paid back at once after the wait ends. This shortens the following interval, so the whole sweep still ends inside the retention window.

Top module: `retention_scrubber`

## Requirements
- R1: During and right after reset, `wb_req`, `inv_req` and `bank_hold` are low and the scan pointer is at set 0, way 0.
- R2: The pacing countdown has a period of INTERVAL = RETAIN_CYCLES / (NUM_SETS*SLOW_WAYS) clock cycles. When no bank waits occur, consecutive invalidations of clean lines are exactly INTERVAL cycles apart.
- R3: The line visiting order raises the way index first, from 0 to SLOW_WAYS-1 inside a set, then moves to the next set. After set NUM_SETS-1, way SLOW_WAYS-1, the pointer wraps to set 0, way 0.
- R4: A line whose `line_valid` is low is skipped. It raises no `wb_req`, no `inv_req` and no `bank_hold`.
- R5: A valid line whose `line_dirty` is low gets a one-cycle `inv_req` pulse, with no `wb_req` and no `bank_hold`.
- R6: A valid dirty line raises `wb_req`. The request stays high, with the scan pointer stable, until `wb_ack`. `inv_req` for the same line follows in the next cycle.
- R7: `bank_hold` is one-hot or zero. During a writeback it holds exactly the bit of the line's way. `wb_req` is never high without a hold. A hold is never granted while that way's `bank_busy` is high.
- R8: When the target bank is busy, the step waits with the pointer held. Intervals that expire during the wait are paid back immediately afterwards. Every line present at the start of a sweep is handled within RETAIN_CYCLES plus a few cycles of writeback latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_set | output | SET_W | Set index of the line under inspection; addresses the control array, the writeback and the invalidation |
| scan_way | output | WAY_W | Slow-way index of the line under inspection |
| line_valid | input | 1 | Valid bit of the addressed line (combinational control-array read) |
| line_dirty | input | 1 | Dirty bit of the addressed line |
| bank_busy | input | SLOW_WAYS | Per-way data bank in use by the main controller |
| bank_hold | output | SLOW_WAYS | Per-way data bank claimed by the scrubber for a writeback read |
| wb_req | output | 1 | Preventive writeback request for the addressed line |
| wb_ack | input | 1 | Next level accepted the writeback |
| inv_req | output | 1 | One-cycle pulse: clear valid and dirty of the addressed line |

## Verification
The hardest condition to reach is a bank wait long enough that more than one interval expires before the writeback can start. This is the only case where the owed-step path carries more than one step and the following intervals get shorter. The bench holds one way's bank busy for well over three intervals, starting right when a new sweep begins, with a dirty line in that way near the front of the order. It then confirms that every line is still emptied inside the retention window. A separate all-clean sweep checks the undisturbed spacing, and an all-invalid sweep checks that skipped lines leave the outputs silent.

// File: rtl/scrub_pkg.sv
// Shared definitions for the retention scrubber.
// Assumes: nothing beyond IEEE 1800-2017.
package scrub_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for an owed step
        ST_WAITB = 2'd1,   // dirty line, bank busy
        ST_WB    = 2'd2,   // bank claimed, writeback outstanding
        ST_INV   = 2'd3    // invalidate the line
    } step_state_t;
endpackage

// File: rtl/scrub_tick_timer.sv
// Free-running pacing countdown plus an owed-step counter.
// Each expiry adds one owed step and each completed step removes one, so a
// stalled step shortens the next interval instead of slipping the sweep.
// Assumes INTERVAL >= 2.
module scrub_tick_timer #(
    parameter int INTERVAL = 100,
    parameter int LINES    = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic consume,
    output logic has_work
);
    localparam int CNT_W  = $clog2(INTERVAL);
    localparam int OWED_W = $clog2(LINES + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [OWED_W-1:0] owed_q;
    logic              tick;

    assign tick     = (cnt_q == '0);
    assign has_work = (owed_q != '0);

    // Countdown that reloads itself on every expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= CNT_W'(INTERVAL - 1);
        else if (tick)  cnt_q <= CNT_W'(INTERVAL - 1);
        else            cnt_q <= cnt_q - 1'b1;
    end

    // Owed steps: raised by expiries, lowered by completed steps.
    always_ff @(posedge clk) begin
        if (!rst_n) owed_q <= '0;
        else if (tick && !consume && owed_q != OWED_W'(LINES)) owed_q <= owed_q + 1'b1;
        else if (!tick && consume) owed_q <= owed_q - 1'b1;
    end
endmodule

// File: rtl/scrub_line_ptr.sv
// Line pointer over the slow ways: way first, then set, wrapping at the end.
// Assumes NUM_SETS >= 2.
module scrub_line_ptr #(
    parameter int NUM_SETS  = 8,
    parameter int SLOW_WAYS = 3,
    parameter int SET_W     = $clog2(NUM_SETS),
    parameter int WAY_W     = (SLOW_WAYS > 1) ? $clog2(SLOW_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [SET_W-1:0] set_o,
    output logic [WAY_W-1:0] way_o
);
    logic last_way, last_set;

    assign last_way = (way_o == WAY_W'(SLOW_WAYS - 1));
    assign last_set = (set_o == SET_W'(NUM_SETS - 1));

    // Step to the next line when a scrub step completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_o <= '0;
            way_o <= '0;
        end else if (advance) begin
            if (last_way) begin
                way_o <= '0;
                set_o <= last_set ? '0 : set_o + 1'b1;
            end else begin
                way_o <= way_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scrub_step_ctrl.sv
// Per-line step sequencer: skip, invalidate, or claim bank + writeback + invalidate.
// Assumes the control array read is combinational on the scan address, and
// that the main controller keeps bank_busy low on a way it sees held.
module scrub_step_ctrl
    import scrub_pkg::*;
#(
    parameter int SLOW_WAYS = 3,
    parameter int WAY_W     = (SLOW_WAYS > 1) ? $clog2(SLOW_WAYS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 has_work,
    input  logic                 line_valid,
    input  logic                 line_dirty,
    input  logic [WAY_W-1:0]     way,
    input  logic [SLOW_WAYS-1:0] bank_busy,
    input  logic                 wb_ack,
    output logic                 consume,
    output logic                 wb_req,
    output logic                 inv_req,
    output logic [SLOW_WAYS-1:0] bank_hold
);
    step_state_t state_q, state_d;
    logic [SLOW_WAYS-1:0] way_sel;
    logic                 target_busy;

    // One-hot decode of the target way, one comparator per slow way.
    for (genvar g = 0; g < SLOW_WAYS; g++) begin : g_way
        assign way_sel[g]   = (way == WAY_W'(g));
        assign bank_hold[g] = (state_q == ST_WB) && way_sel[g];
    end

    assign target_busy = |(bank_busy & way_sel);
    assign wb_req      = (state_q == ST_WB);
    assign inv_req     = (state_q == ST_INV);

    // Next-state and step-completion decode.
    always_comb begin
        state_d = state_q;
        consume = 1'b0;
        unique case (state_q)
            ST_IDLE: if (has_work) begin
                if (!line_valid)      consume = 1'b1;
                else if (!line_dirty) state_d = ST_INV;
                else                  state_d = ST_WAITB;
            end
            ST_WAITB: if (!target_busy) state_d = ST_WB;
            ST_WB:    if (wb_ack)       state_d = ST_INV;
            ST_INV: begin
                consume = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/retention_scrubber.sv
// Top of the retention scrubber: pacing timer, line pointer, step sequencer.
// Assumes RETAIN_CYCLES >= 2 * NUM_SETS * SLOW_WAYS.
module retention_scrubber #(
    parameter int NUM_SETS      = 8,
    parameter int SLOW_WAYS     = 3,
    parameter int RETAIN_CYCLES = 2400,
    parameter int SET_W         = $clog2(NUM_SETS),
    parameter int WAY_W         = (SLOW_WAYS > 1) ? $clog2(SLOW_WAYS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [SET_W-1:0]     scan_set,
    output logic [WAY_W-1:0]     scan_way,
    input  logic                 line_valid,
    input  logic                 line_dirty,
    input  logic [SLOW_WAYS-1:0] bank_busy,
    output logic [SLOW_WAYS-1:0] bank_hold,
    output logic                 wb_req,
    input  logic                 wb_ack,
    output logic                 inv_req
);
    localparam int LINES    = NUM_SETS * SLOW_WAYS;
    localparam int INTERVAL = RETAIN_CYCLES / LINES;

    logic consume, has_work;

    scrub_tick_timer #(.INTERVAL(INTERVAL), .LINES(LINES)) u_timer (
        .clk(clk), .rst_n(rst_n), .consume(consume), .has_work(has_work)
    );

    scrub_line_ptr #(.NUM_SETS(NUM_SETS), .SLOW_WAYS(SLOW_WAYS),
                     .SET_W(SET_W), .WAY_W(WAY_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .advance(consume),
        .set_o(scan_set), .way_o(scan_way)
    );

    scrub_step_ctrl #(.SLOW_WAYS(SLOW_WAYS), .WAY_W(WAY_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .has_work(has_work),
        .line_valid(line_valid), .line_dirty(line_dirty), .way(scan_way),
        .bank_busy(bank_busy), .wb_ack(wb_ack), .consume(consume),
        .wb_req(wb_req), .inv_req(inv_req), .bank_hold(bank_hold)
    );
endmodule

// File: rtl/scrub_checker.sv
// Protocol checks on the scrubber's ports, attached by bind.
module scrub_checker #(
    parameter int SLOW_WAYS = 3,
    parameter int SET_W     = 3,
    parameter int WAY_W     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [SET_W-1:0]     scan_set,
    input logic [WAY_W-1:0]     scan_way,
    input logic                 line_valid,
    input logic [SLOW_WAYS-1:0] bank_busy,
    input logic [SLOW_WAYS-1:0] bank_hold,
    input logic                 wb_req,
    input logic                 wb_ack,
    input logic                 inv_req
);
    // R7
    hold_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_hold));

    // R7
    wb_under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (bank_hold != '0));

    // R7
    hold_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_hold != '0) |-> ((bank_hold & bank_busy) == '0));

    // R6
    wb_hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(scan_set) && $stable(scan_way)));

    // R6
    wb_then_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_ack) |=> inv_req);

    // R5
    inv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |=> !inv_req);

    // R4
    skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && !$past(wb_req)) |-> $past(line_valid));
endmodule

bind retention_scrubber scrub_checker #(
    .SLOW_WAYS(SLOW_WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
) u_scrub_chk (
    .clk(clk), .rst_n(rst_n), .scan_set(scan_set), .scan_way(scan_way),
    .line_valid(line_valid), .bank_busy(bank_busy), .bank_hold(bank_hold),
    .wb_req(wb_req), .wb_ack(wb_ack), .inv_req(inv_req)
);

// File: tb/sim_retention_scrubber.sv
module sim_retention_scrubber;
    localparam int SETS   = 8;
    localparam int WAYS   = 3;
    localparam int RETAIN = 2400;
    localparam int LINES  = SETS * WAYS;
    localparam int INTV   = RETAIN / LINES;
    localparam int SW     = $clog2(SETS);
    localparam int WW     = $clog2(WAYS);
    localparam int K_WB   = 1;
    localparam int K_INV  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [SW-1:0]   scan_set;
    logic [WW-1:0]   scan_way;
    logic            line_valid, line_dirty;
    logic [WAYS-1:0] bank_busy = '0;
    logic [WAYS-1:0] bank_hold;
    logic            wb_req, inv_req;
    logic            wb_ack = 1'b0;

    logic [LINES-1:0] mv = '0;
    logic [LINES-1:0] md = '0;
    int exp_q[$];
    int n_chk = 0, n_bad = 0;
    int cyc = 0, phase = 0, prev_inv = -1, stray = 0, ack_cnt = 0;
    logic wb_prev = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    retention_scrubber #(.NUM_SETS(SETS), .SLOW_WAYS(WAYS), .RETAIN_CYCLES(RETAIN)) u0 (
        .clk(clk), .rst_n(rst_n), .scan_set(scan_set), .scan_way(scan_way),
        .line_valid(line_valid), .line_dirty(line_dirty), .bank_busy(bank_busy),
        .bank_hold(bank_hold), .wb_req(wb_req), .wb_ack(wb_ack), .inv_req(inv_req)
    );

    // Control-array model, read combinationally at the scan address.
    assign line_valid = mv[int'(scan_set) * WAYS + int'(scan_way)];
    assign line_dirty = md[int'(scan_set) * WAYS + int'(scan_way)];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: load a sweep pattern and queue the expected events in visit order (R3).
    task automatic fill(input int mode);
        for (int i = 0; i < LINES; i++) begin
            bit v, d;
            case (mode)
                1: begin v = (i % 3) != 0; d = (i % 3) == 2; end
                2: begin v = (i % 4) != 3; d = (i % 2) == 1; end
                3: begin v = 1'b0; d = 1'b0; end
                default: begin v = 1'b1; d = 1'b0; end
            endcase
            mv[i] = v;
            md[i] = d;
            if (v && d) exp_q.push_back((K_WB << 16) | i);
            if (v)      exp_q.push_back((K_INV << 16) | i);
        end
    endtask

    // Next level: acknowledge each writeback three cycles after it is seen.
    always @(negedge clk) begin
        if (wb_ack) begin
            wb_ack <= 1'b0;
            ack_cnt <= 0;
        end else if (wb_req) begin
            if (ack_cnt == 2) wb_ack <= 1'b1;
            ack_cnt <= ack_cnt + 1;
        end
    end

    // Monitor: pop and compare every writeback start and invalidation.
    always @(negedge clk) begin
        if (rst_n) begin
            int line, item;
            line = int'(scan_set) * WAYS + int'(scan_way);
            if (phase == 3 && (wb_req || inv_req || bank_hold != '0)) stray++;
            if (wb_req) begin
                // R7: hold matches the line's way and that bank is not busy
                chk(bank_hold == WAYS'(1 << scan_way) && !bank_busy[scan_way],
                    "R7", int'(bank_hold), 1 << scan_way);
            end
            if (wb_req && !wb_prev) begin
                item = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                // R6 / R3: writeback for the expected line in order
                chk(item == ((K_WB << 16) | line), "R6", (K_WB << 16) | line, item);
            end
            if (inv_req) begin
                item = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                // R5 / R3: invalidation for the expected line in order
                chk(item == ((K_INV << 16) | line), "R5", (K_INV << 16) | line, item);
                mv[line] = 1'b0;
                md[line] = 1'b0;
                if (phase == 4) begin
                    // R2: undisturbed spacing equals the interval
                    if (prev_inv >= 0) chk(cyc - prev_inv == INTV, "R2", cyc - prev_inv, INTV);
                    prev_inv = cyc;
                end
            end
            wb_prev <= wb_req;
        end
    end

    task automatic wait_wrap();
        do @(negedge clk); while (!(scan_set == SW'(SETS - 1) && scan_way == WW'(WAYS - 1)));
        do @(negedge clk); while (!(scan_set == '0 && scan_way == '0));
    endtask

    task automatic finish_sweep(input string req);
        repeat (RETAIN + 20) @(negedge clk);
        // R8: every line emptied inside the retention window
        chk(mv == '0, req, int'(mv != '0), 0);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!wb_req && !inv_req && bank_hold == '0, "R1", int'({wb_req, inv_req}), 0);
        chk(scan_set == '0 && scan_way == '0, "R1", int'(scan_set) * WAYS + int'(scan_way), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wb_req && !inv_req && bank_hold == '0, "R1", int'({wb_req, inv_req}), 0);

        phase = 1;              // mixed invalid / clean / dirty, no bank conflict
        fill(1);
        finish_sweep("R8");

        wait_wrap();
        phase = 2;              // long busy on way 1 forces owed steps (R8)
        fill(2);
        bank_busy = 3'b010;
        repeat (4 * INTV - 50) @(negedge clk);
        // R8: way-1 dirty line still waiting, no writeback started for it
        chk(mv[1] == 1'b1, "R8", int'(mv[1]), 1);
        bank_busy = '0;
        finish_sweep("R8");

        wait_wrap();
        phase = 3;              // all invalid: nothing must happen (R4)
        fill(3);
        repeat (RETAIN + 20) @(negedge clk);
        chk(stray == 0, "R4", stray, 0);

        wait_wrap();
        phase = 4;              // all clean: spacing and no writeback (R2, R5)
        fill(4);
        finish_sweep("R5");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule